// File: doc/BRIEF.md
# Serial Dual-Channel DAC Command Front End

This block is the digital side of a two-channel 8-bit converter. A host reaches it over a three-wire serial port made up of an active-low select, a serial clock and a data line. Each frame carries one 16-bit command. The block reads two select bits from the command and sends the payload to one of four places: the channel A latch, the channel B latch, a shared holding buffer, or the reference control field. It also takes a speed bit and a power-down bit from every frame. Its outputs are the two codes that reach the converters and the control lines that set the analog settling speed, the power state and the reference source.

The holding buffer lets software preload channel B. A later channel A write then copies the buffer into channel B in the same cycle that A is loaded, so both outputs change together. The serial pins are synchronised into the system clock domain, and all edge detection runs on the synchronised copies.

Top module: `sdac_cmd_if`

## Requirements
- R1: After reset, both codes, the holding buffer, the speed output, the power-down output, the reference select and the format-error flag are all zero.
- R2: A falling select line opens a frame. Data is shifted in most significant bit first, one bit on each falling serial-clock edge. The word is committed after the 16th bit. Later serial-clock edges are ignored until the select line rises and falls again.
- R3: If the select line rises after 1 to 15 bits, the bits received so far are committed, right-aligned, with the upper bits zero. A select pulse that carries no bits commits nothing.
- R4: The word is laid out as follows: bit 15 is the upper select bit, bit 14 is the speed bit, bit 13 is the power bit, bit 12 is the lower select bit, and bits 11..4 carry the 8-bit code.
- R5: Select value 00 ({bit15,bit12}) loads the code into both the channel B latch and the holding buffer.
- R6: Select value 01 loads only the holding buffer. Both output codes stay unchanged.
- R7: Select value 10 loads the code into channel A and, in the same cycle, copies the old holding-buffer value into channel B.
- R8: Select value 11 loads the reference select from bits 1..0 (00 external, 01 internal low, 10 internal high, 11 external). The codes, the buffer and all other data bits are unaffected.
- R9: Every committed frame updates the speed output (1 = fast) and the power-down output (1 = powered down) from bits 14 and 13, whatever the select value.
- R10: A code write (select value other than 11) whose bits 3..0 are not zero sets a sticky format-error flag. The code in bits 11..4 is still loaded. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| code_a | output | 8 | Code applied to converter A |
| code_b | output | 8 | Code applied to converter B |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| power_down | output | 1 | 1 = converters powered down |
| ref_sel | output | 2 | Reference source select |
| fmt_err | output | 1 | Sticky flag for nonzero pad bits in a code write |

## Verification
Some properties are checked by assertions on every cycle. The bit counter never passes 16. A commit lasts exactly one cycle. The codes change only on a commit. A control write leaves both codes alone. A transfer write moves the old buffer into channel B. The format-error flag never clears once set. Other behaviour can be shown only by the bench's scenarios, which drive real serial frames. These cover the field decoding for each select value, the right alignment of short frames, serial clocks ignored after the 16th bit, empty select pulses, and whether the buffer really held the preloaded value.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 12;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    SEL_B_BUF  = 2'b00,
    SEL_BUF    = 2'b01,
    SEL_A_XFER = 2'b10,
    SEL_CTRL   = 2'b11
  } sel_e;

  localparam int BIT_SEL_HI = 15;
  localparam int BIT_SPEED  = 14;
  localparam int BIT_POWER  = 13;
  localparam int BIT_SEL_LO = 12;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic              cmt_vld,
  output logic [WORD_W-1:0] cmt_word
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sel_q, sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              vld_n;
  logic [WORD_W-1:0] word_n;
  logic              sel_fall, sel_rise, sclk_fall;

  assign sel_fall  = sel_q & ~sel_n_s;
  assign sel_rise  = ~sel_q & sel_n_s;
  assign sclk_fall = sclk_q & ~sclk_s;

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    vld_n  = 1'b0;
    word_n = cmt_word;
    if (sel_fall) begin
      cnt_n = '0;
      sh_n  = '0;
    end else if (!sel_n_s && sclk_fall && (cnt_q < FULL)) begin
      sh_n  = {sh_q[WORD_W-2:0], dat_s};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        vld_n  = 1'b1;
        word_n = sh_n;
      end
    end else if (sel_rise && (cnt_q != '0) && (cnt_q < FULL)) begin
      vld_n  = 1'b1;
      word_n = sh_q;
      cnt_n  = FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b1;
      sclk_q   <= 1'b0;
      cnt_q    <= FULL;
      sh_q     <= '0;
      cmt_vld  <= 1'b0;
      cmt_word <= '0;
    end else begin
      sel_q    <= sel_n_s;
      sclk_q   <= sclk_s;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      cmt_vld  <= vld_n;
      cmt_word <= word_n;
    end
  end

  // R2: bit counter never passes the word length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R2/R3: a commit is a single-cycle pulse
  a_r3_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_vld |=> !cmt_vld);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_vld,
  input  logic [WORD_W-1:0] cmt_word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic [1:0]        ref_sel,
  output logic              fmt_err
);
  localparam int PAD_W = DATA_W - CODE_W;

  sel_e              sel;
  logic [CODE_W-1:0] code_in;
  logic              pad_bad;
  logic [CODE_W-1:0] a_n, b_n, buf_n, buf_q;
  logic              fast_n, pd_n, err_n;
  logic [1:0]        ref_n;

  assign sel     = sel_e'({cmt_word[BIT_SEL_HI], cmt_word[BIT_SEL_LO]});
  assign code_in = cmt_word[DATA_W-1 -: CODE_W];

  if (PAD_W > 0) begin : g_pad
    assign pad_bad = |cmt_word[PAD_W-1:0];
  end else begin : g_nopad
    assign pad_bad = 1'b0;
  end

  always_comb begin
    a_n    = code_a;
    b_n    = code_b;
    buf_n  = buf_q;
    fast_n = fast_mode;
    pd_n   = power_down;
    ref_n  = ref_sel;
    err_n  = fmt_err;
    if (cmt_vld) begin
      fast_n = cmt_word[BIT_SPEED];
      pd_n   = cmt_word[BIT_POWER];
      if (sel != SEL_CTRL && pad_bad) err_n = 1'b1;
      unique case (sel)
        SEL_B_BUF: begin
          b_n   = code_in;
          buf_n = code_in;
        end
        SEL_BUF:    buf_n = code_in;
        SEL_A_XFER: begin
          a_n = code_in;
          b_n = buf_q;
        end
        SEL_CTRL:   ref_n = cmt_word[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a     <= '0;
      code_b     <= '0;
      buf_q      <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
      ref_sel    <= 2'b00;
      fmt_err    <= 1'b0;
    end else begin
      code_a     <= a_n;
      code_b     <= b_n;
      buf_q      <= buf_n;
      fast_mode  <= fast_n;
      power_down <= pd_n;
      ref_sel    <= ref_n;
      fmt_err    <= err_n;
    end
  end

  // R5/R7: codes move only on a commit
  a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_vld |=> ($stable(code_a) && $stable(code_b)));

  // R8: control writes leave both codes alone
  a_r8_ctrl_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld && sel == SEL_CTRL) |=> ($stable(code_a) && $stable(code_b)));

  // R7: transfer write puts the previous buffer value into channel B
  a_r7_xfer_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld && sel == SEL_A_XFER) |=> (code_b == $past(buf_q)));

  // R10: format error is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic [1:0]        ref_sel,
  output logic              fmt_err
);
  logic [1:0]        rst_pipe;
  logic              rst_n_i;
  logic [2:0]        pins_s;
  logic              cmt_vld;
  logic [WORD_W-1:0] cmt_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({ser_sel_n, ser_clk, ser_dat}),
    .q     (pins_s)
  );

  sdac_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .sel_n_s  (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .dat_s    (pins_s[0]),
    .cmt_vld  (cmt_vld),
    .cmt_word (cmt_word)
  );

  sdac_regs #(.CODE_W(CODE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cmt_vld    (cmt_vld),
    .cmt_word   (cmt_word),
    .code_a     (code_a),
    .code_b     (code_b),
    .fast_mode  (fast_mode),
    .power_down (power_down),
    .ref_sel    (ref_sel),
    .fmt_err    (fmt_err)
  );
endmodule

// File: tb/sdac_cmd_if_test.sv
module sdac_cmd_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [7:0] code_a, code_b;
  logic fast_mode, power_down, fmt_err;
  logic [1:0] ref_sel;

  always #5 clk = ~clk;

  sdac_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode),
    .power_down(power_down), .ref_sel(ref_sel), .fmt_err(fmt_err)
  );

  typedef struct {
    logic [7:0] a, b;
    logic fast, pd, err;
    logic [1:0] rsel;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [7:0] m_a = 0, m_b = 0, m_buf = 0;
  logic m_fast = 0, m_pd = 0, m_err = 0;
  logic [1:0] m_ref = 0;

  task automatic chk(string tag, string f, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, exp);
    end
  endtask

  // reference model of the requirements (R4..R10)
  task automatic model(logic [15:0] w);
    logic [1:0] s;
    s = {w[15], w[12]};
    m_fast = w[14];
    m_pd   = w[13];
    if (s != 2'b11 && w[3:0] != 0) m_err = 1'b1;
    case (s)
      2'b00: begin m_b = w[11:4]; m_buf = w[11:4]; end
      2'b01: m_buf = w[11:4];
      2'b10: begin m_a = w[11:4]; m_b = m_buf; end
      default: m_ref = w[1:0];
    endcase
  endtask

  task automatic push(string tag);
    exp_t e;
    e.a = m_a; e.b = m_b; e.fast = m_fast; e.pd = m_pd;
    e.err = m_err; e.rsel = m_ref; e.tag = tag;
    q.push_back(e);
    repeat (16) @(posedge clk);
  endtask

  // send nbits (MSB first of the low nbits of w), then extra clocks of 1s
  task automatic send(logic [15:0] w, int nbits, int extra, string tag);
    logic [15:0] got;
    ser_sel_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = w[i]; ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    for (int i = 0; i < extra; i++) begin
      ser_dat = 1'b1; ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    ser_sel_n = 1'b1;
    repeat (4) @(posedge clk);
    got = (nbits >= 16) ? w : (w & ((16'h1 << nbits) - 16'h1));
    if (nbits > 0) model(got);
    push(tag);
  endtask

  // monitor: pops expected items and compares at the outputs
  initial begin
    forever begin
      wait (q.size() > 0);
      repeat (8) @(negedge clk);
      begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "code_a", code_a, e.a);
        chk(e.tag, "code_b", code_b, e.b);
        chk(e.tag, "fast_mode", fast_mode, e.fast);
        chk(e.tag, "power_down", power_down, e.pd);
        chk(e.tag, "ref_sel", ref_sel, e.rsel);
        chk(e.tag, "fmt_err", fmt_err, e.err);
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    push("R1 reset");
    send(16'hDFF6, 16, 0, "R8 ctrl ref=high fast");
    send(16'h1AB0, 16, 0, "R6 buffer only");
    send(16'h8CD0, 16, 0, "R7 A write with B transfer");
    send(16'h0120, 16, 0, "R5 B and buffer");
    send(16'h2000, 16, 0, "R9 power-down only word");
    send(16'h0345, 16, 0, "R10 pad error loads code");
    send(16'h0560, 16, 0, "R10 error stays set");
    send(16'h1420, 16, 4, "R2 extra clocks ignored");
    send(16'h8770, 16, 0, "R2 R4 buffer kept 42");
    send(16'h0350, 10, 0, "R3 short frame right-aligned");
    send(16'h0000, 0, 0, "R3 empty select pulse");
    send(16'hF001, 16, 0, "R8 R9 ref=low fast pd");
    wait (q.size() == 0);
    repeat (12) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule